// File: doc/BRIEF.md
# UART Transmit Path with Holding and Shift Status

This block is the transmit half of a serial port. The host writes one byte at a time into a single holding register. A separate shift register takes the byte over and sends a frame on the line, one bit per baud tick. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The baud tick comes from outside, so the bit rate is set elsewhere.

The holding register hands its byte to the shifter on a baud tick. That happens when the shifter is idle, or on the tick that ends the last stop bit of the current frame. Two flags report progress. The holding-empty flag rises as soon as the byte moves into the shifter, so the host may write the next byte while the current frame is still on the line. The transmitter-empty flag rises only when both registers are empty and the line is idle. When the host enables it, a level interrupt request follows the holding-empty flag.

The frame format is taken at the moment of each transfer. Changing it while a frame is on the line has no effect on that frame.

Top module: `uart_tx_status`

## Requirements
- R1: After reset, tx_o is 1 and line_stat_o reads 8'h60 (bit 5 and bit 6 set). tx_irq_o equals int_en_i[1].
- R2: A write, which is wr_en_i high at a clock edge, clears line_stat_o bit 5 (holding empty) and bit 6 (transmitter empty). Both show 0 from that edge onward.
- R3: The holding byte moves to the shifter only on a clock edge where baud_tick_i is high. When the shifter is idle, this is the first such edge after the write. Bit 5 returns to 1 on that edge, and bit 6 stays 0.
- R4: Each frame opens with a start bit of 0 that lasts one tick period. The data bits follow, least significant first. The number of data bits is word_len_i + 5 (encoding 0 gives 5 bits, 3 gives 8 bits). Data bits above that width are not sent.
- R5: When parity_en_i is 1, one parity bit follows the data. With parity_even_i = 1, the data bits plus the parity bit hold an even number of ones. With parity_even_i = 0, they hold an odd number.
- R6: One stop bit of 1 ends the frame when stop2_i = 0, and two stop bits of 1 end it when stop2_i = 1.
- R7: When the holding register is full at the tick that ends the last stop bit, the next start bit begins on that same tick, with no idle bit time between the frames.
- R8: A write while the holding register is full replaces the pending byte. Only the last byte written is sent.
- R9: tx_irq_o equals int_en_i[1] AND holding-empty. The other int_en_i bits have no effect on it.
- R10: line_stat_o bits 0 to 4 and bit 7 always read 0.
- R11: On the tick that ends the last stop bit with the holding register empty, bit 6 rises to 1. tx_o stays 1 for as long as the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Adds a parity bit |
| parity_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| stop2_i | input | 1 | 1 selects two stop bits |
| int_en_i | input | 4 | Interrupt enables; bit 1 is the transmit enable |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| tx_o | output | 1 | Serial line, idle high |
| line_stat_o | output | 8 | Bit 5 is holding empty, bit 6 is transmitter empty, other bits are 0 |
| tx_irq_o | output | 1 | Transmit interrupt request (level) |

## Verification
The bench goes after the frame seam, where a second byte written during the first frame must start on the very tick that ends the first frame's stop bit. A design that inserted an idle bit there would show a 1 where the bench expects the start bit 0. Flag timing is checked on both sides of the transfer. A design that raised holding-empty only at the end of the line would keep the flag at 0 during the whole frame. A design that raised transmitter-empty at the transfer would report idle while the line is still busy.

Narrow words with both parities and two stop bits are checked to catch a parity sense that is inverted, and to catch data bits leaking above the chosen width. The overwrite case checks that two writes before a tick send only the second byte. The interrupt case checks that the other enable bits cannot raise the request.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_MAX = 8;
  localparam int unsigned FRAME_W  = DATA_MAX + 4;
  localparam int unsigned CNT_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] word_len;
    logic       par_en;
    logic       par_even;
    logic       stop2;
  } tx_cfg_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [CNT_W-1:0]   len;
  } tx_frame_t;

  function automatic tx_frame_t build_frame(input logic [DATA_MAX-1:0] data,
                                            input tx_cfg_t cfg);
    tx_frame_t f;
    int unsigned nd;
    logic par;
    nd     = 5 + int'(cfg.word_len);
    f.bits = '1;
    f.bits[0] = 1'b0;
    par = 1'b0;
    for (int unsigned i = 0; i < DATA_MAX; i++) begin
      if (i < nd) begin
        f.bits[1+i] = data[i];
        par = par ^ data[i];
      end
    end
    if (cfg.par_en) f.bits[1+nd] = cfg.par_even ? par : ~par;
    f.len = CNT_W'(1 + nd + (cfg.par_en ? 1 : 0) + (cfg.stop2 ? 2 : 1));
    return f;
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          xfer_i,
  output logic          full_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_en_i) begin
      // write wins over a same-cycle transfer; shifter already took the old byte
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (xfer_i) begin
      full_o <= 1'b0;
    end
  end

  a_r2_write_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> full_o);
  a_r8_last_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> data_o == $past(wr_data_i));
  a_r3_empty_only_by_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !wr_en_i && !xfer_i) |=> full_o);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               hold_full_i,
  input  tx_frame_t          frame_i,
  output logic               xfer_o,
  output logic               busy_o,
  output logic               tx_o
);
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   left_q;
  logic               last_bit;

  assign last_bit = busy_o && (left_q == CNT_W'(1));
  assign xfer_o   = tick_i && hold_full_i && (!busy_o || last_bit);
  assign tx_o     = shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      left_q  <= '0;
      busy_o  <= 1'b0;
    end else if (tick_i) begin
      if (xfer_o) begin
        shreg_q <= frame_i.bits;
        left_q  <= frame_i.len;
        busy_o  <= 1'b1;
      end else if (busy_o) begin
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - CNT_W'(1);
        if (last_bit) busy_o <= 1'b0;
      end
    end
  end

  a_r11_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  a_r7_start_on_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> (busy_o && !tx_o));
  a_r3_bits_move_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_o));
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
  import uart_tx_pkg::*;
#(
  parameter int unsigned IE_W    = 4,
  parameter int unsigned IRQ_BIT = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_MAX-1:0] wr_data_i,
  input  logic [1:0]          word_len_i,
  input  logic                parity_en_i,
  input  logic                parity_even_i,
  input  logic                stop2_i,
  input  logic [IE_W-1:0]     int_en_i,
  input  logic                baud_tick_i,
  output logic                tx_o,
  output logic [7:0]          line_stat_o,
  output logic                tx_irq_o
);
  logic                hold_full, xfer, busy;
  logic [DATA_MAX-1:0] hold_data;
  tx_cfg_t             cfg;
  tx_frame_t           frame;
  logic                hold_empty, xmit_empty;

  assign cfg   = '{word_len: word_len_i, par_en: parity_en_i,
                   par_even: parity_even_i, stop2: stop2_i};
  assign frame = build_frame(hold_data, cfg);

  tx_hold_reg #(.DW(DATA_MAX)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .xfer_i    (xfer),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  tx_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (baud_tick_i),
    .hold_full_i (hold_full),
    .frame_i     (frame),
    .xfer_o      (xfer),
    .busy_o      (busy),
    .tx_o        (tx_o)
  );

  assign hold_empty  = !hold_full;
  assign xmit_empty  = !hold_full && !busy;
  assign line_stat_o = {1'b0, xmit_empty, hold_empty, 5'b0};
  assign tx_irq_o    = int_en_i[IRQ_BIT] && hold_empty;

  a_r3_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_stat_o[5]) |-> $past(baud_tick_i));
  a_r11_empty_implies_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_stat_o[6] |-> (line_stat_o[5] && tx_o));
  a_r2_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (!line_stat_o[5] && !line_stat_o[6]));
  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> int_en_i[IRQ_BIT]);
endmodule

// File: tb/uart_tx_status_tb_top.sv
module uart_tx_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, stop2 = 1'b0;
  logic [3:0] int_en = 4'b0010;
  logic       tick = 1'b0;
  logic [1:0] tick_cnt = '0;
  logic       tx;
  logic [7:0] stat;
  logic       irq;
  int         n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt <= tick_cnt + 2'd1;
    tick     <= (tick_cnt == 2'd3);
  end

  uart_tx_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .word_len_i(word_len), .parity_en_i(par_en), .parity_even_i(par_even),
    .stop2_i(stop2), .int_en_i(int_en), .baud_tick_i(tick),
    .tx_o(tx), .line_stat_o(stat), .tx_irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected frame built from R4..R6
  int   exp_len;
  logic exp_bits [0:11];
  task automatic make_frame(input logic [7:0] d);
    int nd; logic p;
    nd = 5 + int'(word_len);
    p  = 1'b0;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      exp_bits[1+i] = d[i];
      p ^= d[i];
    end
    exp_len = 1 + nd;
    if (par_en) begin
      exp_bits[exp_len] = par_even ? p : ~p;
      exp_len++;
    end
    exp_bits[exp_len] = 1'b1; exp_len++;
    if (stop2) begin exp_bits[exp_len] = 1'b1; exp_len++; end
  endtask

  task automatic next_tick();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_reserved();
    chk("R10", "reserved status bits", {stat[7], 2'b0, stat[4:0]}, 8'h00);
  endtask

  // remaining bits 1..len-1 of the expected frame
  task automatic check_rest(input string tag);
    for (int k = 1; k < exp_len; k++) begin
      next_tick();
      chk(k >= exp_len - (stop2 ? 2 : 1) ? "R6" : (par_en && k == exp_len - (stop2 ? 3 : 2)) ? "R5" : "R4",
          $sformatf("%s bit %0d", tag, k), {7'b0, tx}, {7'b0, exp_bits[k]});
      chk("R11", "transmitter busy during frame", {7'b0, stat[6]}, 8'h00);
    end
  endtask

  task automatic test_reset();
    chk("R1", "tx after reset", {7'b0, tx}, 8'h01);
    chk("R1", "status after reset", stat, 8'h60);
    chk("R1", "irq after reset", {7'b0, irq}, 8'h01);
  endtask

  task automatic test_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                            input logic pev, input logic s2, input string tag);
    word_len = wl; par_en = pe; par_even = pev; stop2 = s2;
    make_frame(d);
    next_tick();
    write_byte(d);
    chk("R2", {tag, " status after write"}, stat, 8'h00);
    next_tick();
    chk("R4", {tag, " start bit"}, {7'b0, tx}, 8'h00);
    chk("R3", {tag, " status after transfer"}, stat, 8'h20);
    check_rest(tag);
    next_tick();
    chk("R11", {tag, " line idle after frame"}, {7'b0, tx}, 8'h01);
    chk("R11", {tag, " status idle"}, stat, 8'h60);
    check_reserved();
  endtask

  task automatic test_back_to_back();
    word_len = 2'd3; par_en = 1'b1; par_even = 1'b0; stop2 = 1'b0;
    next_tick();
    write_byte(8'h81);
    next_tick();
    chk("R3", "first byte moved", stat, 8'h20);
    write_byte(8'h7E);
    chk("R2", "second write clears hold empty", stat, 8'h00);
    make_frame(8'h81);
    check_rest("b2b first");
    next_tick();
    chk("R7", "second start bit with no gap", {7'b0, tx}, 8'h00);
    chk("R7", "hold empty after second transfer", stat, 8'h20);
    make_frame(8'h7E);
    check_rest("b2b second");
    next_tick();
    chk("R11", "idle after back to back", stat, 8'h60);
  endtask

  task automatic test_overwrite();
    word_len = 2'd3; par_en = 1'b0; stop2 = 1'b0;
    next_tick();
    write_byte(8'h11);
    write_byte(8'hC6);
    chk("R8", "still full after overwrite", stat, 8'h00);
    make_frame(8'hC6);
    next_tick();
    chk("R8", "start bit of overwritten byte", {7'b0, tx}, 8'h00);
    check_rest("overwrite");
    next_tick();
    chk("R8", "single frame only", stat, 8'h60);
    chk("R8", "line idle after overwrite", {7'b0, tx}, 8'h01);
  endtask

  task automatic test_irq();
    int_en = 4'b1101;
    @(negedge clk);
    chk("R9", "irq with only other enables", {7'b0, irq}, 8'h00);
    int_en = 4'b0010;
    @(negedge clk);
    chk("R9", "irq when enabled and empty", {7'b0, irq}, 8'h01);
    next_tick();
    write_byte(8'h55);
    chk("R9", "irq drops after write", {7'b0, irq}, 8'h00);
    next_tick();
    chk("R9", "irq back after transfer", {7'b0, irq}, 8'h01);
    make_frame(8'h55);
    check_rest("irq");
    next_tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, "8N1");
    test_frame(8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, "5E1");
    test_frame(8'hBC, 2'd2, 1'b1, 1'b0, 1'b1, "7O2");
    test_frame(8'h2D, 2'd1, 1'b1, 1'b1, 1'b1, "6E2");
    test_back_to_back();
    test_overwrite();
    test_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule